// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit for an 8-bit Accumulator Core

This unit performs the two long arithmetic operations of an 8-bit accumulator machine over several clock cycles. The accumulator byte and the C register byte are joined into one 16-bit operand, with the accumulator as the upper byte. The B register byte is the second operand. A multiply forms a 24-bit product and a divide forms a 16-bit quotient with an 8-bit remainder. The results go back onto the three register byte outputs in a fixed arrangement that the surrounding core writes back.

The core pulses `start_i` for one cycle, with `div_i` selecting the operation and the three register values on the inputs. A fixed number of clock edges later the unit raises `done_o` for one cycle. The new accumulator, C, B, carry and overflow values are then on the outputs. They stay there until the next accepted start. While an operation runs, the byte outputs show intermediate work and must not be used. Decoding and register writeback belong to the core.

Top module: `seq_muldiv`

## Requirements
- R1: With `div_i`=0 (multiply), `{acc_i,c_i}` is multiplied by `b_i`. At completion the product's bits 23..16 are on `b_o`, bits 15..8 on `acc_o` and bits 7..0 on `c_o`.
- R2: With `div_i`=1 (divide) and `b_i` nonzero, `{acc_i,c_i}` is divided by `b_i`. At completion the quotient's upper byte is on `acc_o`, its lower byte on `c_o`, and the remainder on `b_o`.
- R3: An accepted start is sampled on a clock edge. `done_o` is high exactly during the cycle after the 7th following edge (LATENCY = 7), for one cycle only.
- R4: `cy_o` is 0 at completion of both operations.
- R5: After a multiply, `ov_o` is 1 when the product is 65536 or more (`b_o` nonzero) and 0 otherwise.
- R6: After a divide by a nonzero value, `ov_o` is 1 when the remainder is zero and 0 otherwise.
- R7: A divide by zero gives quotient 0xFFFF (`acc_o`=`c_o`=0xFF), puts `c_i` on `b_o` and sets `ov_o`.
- R8: A start pulse that arrives while an operation is running is ignored. It neither moves the completion cycle nor changes the results, and it produces no second `done_o`.
- R9: Between `done_o` and the next accepted start, `acc_o`, `c_o`, `b_o` and `ov_o` keep their values.
- R10: Reset (active-low `rst_n`, asynchronous) clears all outputs to 0 and abandons a running operation, so no `done_o` follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin an operation |
| div_i | input | 1 | Operation select: 0 multiply, 1 divide |
| acc_i | input | 8 | Accumulator value, upper byte of the 16-bit operand |
| c_i | input | 8 | C register value, lower byte of the 16-bit operand |
| b_i | input | 8 | B register value, multiplier or divisor |
| acc_o | output | 8 | New accumulator value |
| c_o | output | 8 | New C register value |
| b_o | output | 8 | New B register value |
| cy_o | output | 1 | New carry flag |
| ov_o | output | 1 | New overflow flag |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a second start arriving while the unit is busy. It would be easy to miss either a silent restart or a second completion. The bench issues a multiply, then pulses a divide-by-zero request with different operands two cycles later. It checks that completion still comes 7 edges after the first start, that the multiply results appear, and that no further done pulse follows. Divide by zero and the product just reaching 17 bits are table entries. A reset in the middle of an operation is driven directly, and the bench then confirms that no stale completion appears.

// File: rtl/seq_muldiv_pkg.sv
`timescale 1ns/1ps
package seq_muldiv_pkg;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } mdu_op_e;

endpackage

// File: rtl/seq_muldiv_mul_step.sv
`timescale 1ns/1ps
// One radix-2^STEP_BITS multiply step, most significant digit first:
// the partial product is shifted up one digit and the next digit's
// contribution is added.
module seq_muldiv_mul_step #(
    parameter int WIDE_W    = 16,
    parameter int NARROW_W  = 8,
    parameter int STEP_BITS = 4
) (
    input  logic [WIDE_W+NARROW_W-1:0] work_i,
    input  logic [WIDE_W-1:0]          mpl_i,
    input  logic [NARROW_W-1:0]        mcand_i,
    output logic [WIDE_W+NARROW_W-1:0] work_o,
    output logic [WIDE_W-1:0]          mpl_o
);
    localparam int PROD_W = WIDE_W + NARROW_W;
    localparam int PART_W = NARROW_W + STEP_BITS;

    logic [STEP_BITS-1:0] digit;
    logic [PART_W-1:0]    part;

    assign digit  = mpl_i[WIDE_W-1 -: STEP_BITS];
    assign part   = {{STEP_BITS{1'b0}}, mcand_i} * {{NARROW_W{1'b0}}, digit};
    assign work_o = (work_i << STEP_BITS) + PROD_W'(part);
    assign mpl_o  = mpl_i << STEP_BITS;
endmodule

// File: rtl/seq_muldiv_div_step.sv
`timescale 1ns/1ps
// STEP_BITS restoring-division bits per cycle. Dividend bits leave the
// top of quo while quotient bits enter at the bottom.
module seq_muldiv_div_step #(
    parameter int WIDE_W    = 16,
    parameter int NARROW_W  = 8,
    parameter int STEP_BITS = 4
) (
    input  logic [NARROW_W-1:0] rem_i,
    input  logic [WIDE_W-1:0]   quo_i,
    input  logic [NARROW_W-1:0] dvs_i,
    output logic [NARROW_W-1:0] rem_o,
    output logic [WIDE_W-1:0]   quo_o
);
    always_comb begin
        logic [NARROW_W:0]   trial;
        logic                take;
        logic [NARROW_W-1:0] rem;
        logic [WIDE_W-1:0]   quo;
        rem = rem_i;
        quo = quo_i;
        for (int i = 0; i < STEP_BITS; i++) begin
            trial = {rem, quo[WIDE_W-1]};
            take  = (trial >= {1'b0, dvs_i});
            rem   = take ? NARROW_W'(trial - {1'b0, dvs_i}) : trial[NARROW_W-1:0];
            quo   = {quo[WIDE_W-2:0], take};
        end
        rem_o = rem;
        quo_o = quo;
    end
endmodule

// File: rtl/seq_muldiv.sv
`timescale 1ns/1ps
module seq_muldiv
    import seq_muldiv_pkg::*;
#(
    parameter int NARROW_W  = 8,
    parameter int LATENCY   = 7,
    parameter int STEP_BITS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                div_i,
    input  logic [NARROW_W-1:0] acc_i,
    input  logic [NARROW_W-1:0] c_i,
    input  logic [NARROW_W-1:0] b_i,
    output logic [NARROW_W-1:0] acc_o,
    output logic [NARROW_W-1:0] c_o,
    output logic [NARROW_W-1:0] b_o,
    output logic                cy_o,
    output logic                ov_o,
    output logic                done_o
);
    localparam int WIDE_W = 2 * NARROW_W;
    localparam int PROD_W = WIDE_W + NARROW_W;
    localparam int STEPS  = WIDE_W / STEP_BITS;
    localparam int CNT_W  = $clog2(LATENCY + 1);

    typedef struct packed {
        logic                busy;
        mdu_op_e             op;
        logic [CNT_W-1:0]    cnt;
        logic [NARROW_W-1:0] opnd;
        logic [WIDE_W-1:0]   mpl;
        logic [PROD_W-1:0]   work;
        logic                ov;
        logic                done;
    } state_t;

    state_t s_d, s_q;

    logic [PROD_W-1:0]   mul_work_d;
    logic [WIDE_W-1:0]   mul_mpl_d;
    logic [NARROW_W-1:0] div_rem_d;
    logic [WIDE_W-1:0]   div_quo_d;

    seq_muldiv_mul_step #(
        .WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .STEP_BITS(STEP_BITS)
    ) u_mul_step (
        .work_i  (s_q.work),
        .mpl_i   (s_q.mpl),
        .mcand_i (s_q.opnd),
        .work_o  (mul_work_d),
        .mpl_o   (mul_mpl_d)
    );

    seq_muldiv_div_step #(
        .WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .STEP_BITS(STEP_BITS)
    ) u_div_step (
        .rem_i (s_q.work[PROD_W-1 -: NARROW_W]),
        .quo_i (s_q.work[WIDE_W-1:0]),
        .dvs_i (s_q.opnd),
        .rem_o (div_rem_d),
        .quo_o (div_quo_d)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start_i) begin
                s_d.busy = 1'b1;
                s_d.op   = div_i ? OP_DIV : OP_MUL;
                s_d.cnt  = '0;
                s_d.opnd = b_i;
                s_d.mpl  = {acc_i, c_i};
                s_d.work = div_i ? {{NARROW_W{1'b0}}, acc_i, c_i} : '0;
            end
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt < CNT_W'(STEPS)) begin
                if (s_q.op == OP_DIV) begin
                    s_d.work = {div_rem_d, div_quo_d};
                end else begin
                    s_d.work = mul_work_d;
                    s_d.mpl  = mul_mpl_d;
                end
            end
            if (s_q.cnt == CNT_W'(LATENCY - 1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                if (s_q.op == OP_DIV)
                    s_d.ov = (s_q.work[PROD_W-1 -: NARROW_W] == '0) || (s_q.opnd == '0);
                else
                    s_d.ov = (s_q.work[PROD_W-1 -: NARROW_W] != '0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign b_o    = s_q.work[PROD_W-1 -: NARROW_W];
    assign acc_o  = s_q.work[WIDE_W-1 -: NARROW_W];
    assign c_o    = s_q.work[NARROW_W-1:0];
    assign cy_o   = 1'b0;
    assign ov_o   = s_q.ov;
    assign done_o = s_q.done;
endmodule

// File: rtl/seq_muldiv_chk.sv
`timescale 1ns/1ps
module seq_muldiv_chk #(
    parameter int NARROW_W = 8,
    parameter int LATENCY  = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic                div_i,
    input logic [NARROW_W-1:0] acc_i,
    input logic [NARROW_W-1:0] c_i,
    input logic [NARROW_W-1:0] b_i,
    input logic [NARROW_W-1:0] acc_o,
    input logic [NARROW_W-1:0] c_o,
    input logic [NARROW_W-1:0] b_o,
    input logic                cy_o,
    input logic                ov_o,
    input logic                done_o
);
    localparam int WIDE_W = 2 * NARROW_W;
    localparam int PROD_W = WIDE_W + NARROW_W;
    localparam int CNT_W  = $clog2(LATENCY + 1);

    logic                chk_busy;
    logic [CNT_W-1:0]    chk_cnt;
    logic                op_div;
    logic [WIDE_W-1:0]   op_wide;
    logic [NARROW_W-1:0] op_b;
    logic [PROD_W-1:0]   mul_ref;
    logic [PROD_W-1:0]   div_back;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_busy <= 1'b0;
            chk_cnt  <= '0;
            op_div   <= 1'b0;
            op_wide  <= '0;
            op_b     <= '0;
        end else if (!chk_busy) begin
            if (start_i) begin
                chk_busy <= 1'b1;
                chk_cnt  <= '0;
                op_div   <= div_i;
                op_wide  <= {acc_i, c_i};
                op_b     <= b_i;
            end
        end else begin
            chk_cnt <= chk_cnt + 1'b1;
            if (chk_cnt == CNT_W'(LATENCY - 1)) chk_busy <= 1'b0;
        end
    end

    assign mul_ref  = PROD_W'(op_wide) * PROD_W'(op_b);
    assign div_back = PROD_W'({acc_o, c_o}) * PROD_W'(op_b) + PROD_W'(b_o);

    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!chk_busy && chk_cnt == CNT_W'(LATENCY)));
    p_done_due_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_busy && chk_cnt == CNT_W'(LATENCY - 1)) |=> done_o);
    p_no_early_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_busy && chk_cnt != CNT_W'(LATENCY - 1)) |=> !done_o);
    p_mul_result_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !op_div) |-> ({b_o, acc_o, c_o} == mul_ref));
    p_div_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_div && op_b != '0) |-> (div_back == PROD_W'(op_wide) && b_o < op_b));
    p_carry_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !cy_o);
    p_mul_ov_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !op_div) |-> (ov_o == (b_o != '0)));
    p_div_ov_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_div && op_b != '0) |-> (ov_o == (b_o == '0)));
    p_div_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_div && op_b == '0) |-> ({acc_o, c_o} == '1 && b_o == op_wide[NARROW_W-1:0] && ov_o));
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!chk_busy && !start_i) |=> $stable({acc_o, c_o, b_o, ov_o}));
endmodule

bind seq_muldiv seq_muldiv_chk #(.NARROW_W(NARROW_W), .LATENCY(LATENCY)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .div_i(div_i),
    .acc_i(acc_i), .c_i(c_i), .b_i(b_i),
    .acc_o(acc_o), .c_o(c_o), .b_o(b_o),
    .cy_o(cy_o), .ov_o(ov_o), .done_o(done_o)
);

// File: tb/seq_muldiv_bench.sv
`timescale 1ns/1ps
module seq_muldiv_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       div_i = 1'b0;
    logic [7:0] acc_i = '0, c_i = '0, b_i = '0;
    logic [7:0] acc_o, c_o, b_o;
    logic       cy_o, ov_o, done_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    seq_muldiv u_seq_muldiv (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .div_i(div_i),
        .acc_i(acc_i), .c_i(c_i), .b_i(b_i),
        .acc_o(acc_o), .c_o(c_o), .b_o(b_o),
        .cy_o(cy_o), .ov_o(ov_o), .done_o(done_o)
    );

    // {div, acc, c, b, exp_b, exp_acc, exp_c, exp_ov}
    localparam int NV = 12;
    localparam logic [49:0] VEC [NV] = '{
        {1'b0, 8'h00, 8'h03, 8'h05, 8'h00, 8'h00, 8'h0F, 1'b0},
        {1'b0, 8'h12, 8'h34, 8'h10, 8'h01, 8'h23, 8'h40, 1'b1},
        {1'b0, 8'hFF, 8'hFF, 8'hFF, 8'hFE, 8'hFF, 8'h01, 1'b1},
        {1'b0, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0},
        {1'b0, 8'h80, 8'h00, 8'h02, 8'h01, 8'h00, 8'h00, 1'b1},
        {1'b0, 8'h7F, 8'hFF, 8'h02, 8'h00, 8'hFF, 8'hFE, 1'b0},
        {1'b1, 8'h00, 8'h64, 8'h0A, 8'h00, 8'h00, 8'h0A, 1'b1},
        {1'b1, 8'h12, 8'h34, 8'h10, 8'h04, 8'h01, 8'h23, 1'b0},
        {1'b1, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h01, 8'h01, 1'b1},
        {1'b1, 8'h00, 8'h05, 8'h07, 8'h05, 8'h00, 8'h00, 1'b0},
        {1'b1, 8'hAB, 8'hCD, 8'h00, 8'hCD, 8'hFF, 8'hFF, 1'b1},
        {1'b1, 8'h12, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF, 1'b1}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Start pulse sampled on one edge; returns edges until done is seen.
    task automatic run_op(input logic dv, input logic [7:0] a, input logic [7:0] c,
                          input logic [7:0] b, output int lat);
        @(negedge clk);
        start_i = 1'b1; div_i = dv; acc_i = a; c_i = c; b_i = b;
        @(negedge clk);
        start_i = 1'b0; acc_i = '0; c_i = '0; b_i = '0;
        lat = 0;
        while (!done_o && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R3 watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R10: reset state
        check({acc_o, c_o, b_o, ov_o, done_o, cy_o} == '0, "R10", "outputs in reset",
              {acc_o, c_o, b_o, ov_o, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({acc_o, c_o, b_o, ov_o, done_o} == '0, "R10", "outputs after reset",
              {acc_o, c_o, b_o, ov_o, done_o}, 0);

        // Table walk: R1, R2, R4, R5, R6, R7, R3
        for (int i = 0; i < NV; i++) begin
            logic [49:0] v;
            string rq;
            v = VEC[i];
            run_op(v[49], v[48:41], v[40:33], v[32:25], lat);
            rq = !v[49] ? "R1" : (v[32:25] == 8'h00 ? "R7" : "R2");
            check(lat == 7, "R3", "latency", lat, 7);
            check({b_o, acc_o, c_o} == v[24:1], rq, "result {b,acc,c}",
                  {b_o, acc_o, c_o}, v[24:1]);
            check(ov_o == v[0], !v[49] ? "R5" : (v[32:25] == 8'h00 ? "R7" : "R6"),
                  "overflow flag", ov_o, v[0]);
            check(cy_o == 1'b0, "R4", "carry flag", cy_o, 0);
            @(negedge clk);
            check(done_o == 1'b0, "R3", "done width", done_o, 0);
        end

        // R9: results hold while idle
        run_op(1'b0, 8'h12, 8'h34, 8'h10, lat);
        repeat (6) @(negedge clk);
        check({b_o, acc_o, c_o, ov_o} == {24'h012340, 1'b1}, "R9", "held result",
              {b_o, acc_o, c_o, ov_o}, {24'h012340, 1'b1});

        // R8: start during busy ignored
        @(negedge clk);
        start_i = 1'b1; div_i = 1'b0; acc_i = 8'h00; c_i = 8'h03; b_i = 8'h05;
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        repeat (2) begin @(negedge clk); lat++; end
        start_i = 1'b1; div_i = 1'b1; acc_i = 8'hAB; c_i = 8'hCD; b_i = 8'h00;
        @(negedge clk); lat++;
        start_i = 1'b0;
        while (!done_o && lat < 20) begin @(negedge clk); lat++; end
        check(lat == 7, "R8", "latency with extra start", lat, 7);
        check({b_o, acc_o, c_o, ov_o} == {24'h00000F, 1'b0}, "R8", "result of first op",
              {b_o, acc_o, c_o, ov_o}, {24'h00000F, 1'b0});
        begin
            int extra = 0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (done_o) extra++;
            end
            check(extra == 0, "R8", "no second done", extra, 0);
        end

        // R10: reset in the middle of an operation
        @(negedge clk);
        start_i = 1'b1; div_i = 1'b0; acc_i = 8'hFF; c_i = 8'hFF; b_i = 8'hFF;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check({acc_o, c_o, b_o, ov_o, done_o} == '0, "R10", "mid-op reset",
              {acc_o, c_o, b_o, ov_o, done_o}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        begin
            int seen = 0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (done_o) seen++;
            end
            check(seen == 0, "R10", "no done after abandoned op", seen, 0);
        end

        summary();
        $finish;
    end
endmodule